// File: doc/BRIEF.md
# Programmable Hardware Watchdog Timer

This block is a system watchdog. Software arms it with a 16-bit timeout, starts it, and must keep writing a trigger bit before the timeout runs out. If the countdown reaches zero, the block raises a single-cycle request towards the reset or power sequencer: a reboot request or a shutdown request, whichever software chose. It also records that it fired, in a status bit that the warm reset it provokes does not clear. Boot firmware can therefore tell that the last restart came from the watchdog.

Two register spaces control it. A memory-mapped pair holds the control word (offset 0x00) and the count word (offset 0x04). A separate configuration space is reached through an index/data byte port. It holds a global enable that also gates the decode of the memory-mapped pair, and a two-bit field that selects one of four tick periods. A generic clock drives the block. The tick periods are given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter.

Top module: `wdog_top`

## Requirements
- R1: On the configuration port, a write with `cfg_sel_data`=0 loads the index byte, which reads back on `cfg_rdata` when `cfg_sel_data`=0. Data index 0x00 holds the enable in bit 7, and data index 0x03 holds the tick select in bits 1:0. All other bits, and all other indices, read as zero.
- R2: While the enable is 0, writes to the control and count words have no effect, both words read as zero, and the counter does not run.
- R3: Control word bit positions are fixed: start is bit 0, fired is bit 1, action is bit 2 (0 = reboot, 1 = shutdown) and trigger is bit 7. Bits 6:4 and the trigger bit always read as zero, and writes to bits 6:4 are ignored.
- R4: The count word at 0x04 takes the timeout from its low 16 bits. Reads return the remaining tick count in the low 16 bits, with bits 31:16 zero.
- R5: Writing 1 to the trigger bit loads the remaining count from the timeout and restarts the tick phase. The first decrement comes one full tick period after the write.
- R6: Tick select codes 0, 1, 2 and 3 give tick periods of RES0_US, RES1_US, RES2_US and RES3_US microseconds. Each period is that value times CYC_PER_US clock cycles.
- R7: A change of the tick select restarts the prescaler. The next tick comes one full new period after the cycle that follows the write.
- R8: With start at 0, the remaining count holds its value and no request is raised.
- R9: When a tick takes the count to zero while running, exactly one of `reboot_req` (action 0) or `shutdown_req` (action 1) is high for one cycle, in the cycle in which the count first reads zero. Counting then halts until a trigger or a 0-to-1 start write.
- R10: Fired is set at expiry. Writing 1 to bit 1 clears it, and writing 0 to bit 1 leaves it set.
- R11: `rst` clears every register except fired. `por` clears fired as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous warm reset, active high; fired survives it |
| por | input | 1 | Synchronous power-on reset, active high; clears everything |
| reg_wr | input | 1 | Write strobe for the memory-mapped words |
| reg_addr | input | 8 | Byte offset of the memory-mapped word |
| reg_wdata | input | 32 | Write data for the memory-mapped word |
| reg_rdata | output | 32 | Read data of the word at `reg_addr` |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_wdata | input | 8 | Configuration port write byte |
| cfg_rdata | output | 8 | Configuration port read byte |
| reboot_req | output | 1 | One-cycle reboot request on expiry |
| shutdown_req | output | 1 | One-cycle shutdown request on expiry |

## Verification
The bench builds the block with CYC_PER_US = 2 and tick periods of 3, 5, 7 and 11 microseconds, so the four ticks last 6, 10, 14 and 22 cycles. At these sizes, every tick select can be swept through a complete countdown and expiry, and the bench predicts each decrement cycle from the period arithmetic. The same small periods make it affordable to check a mid-count trigger, a stop, a resolution change in the middle of a tick, and a warm reset that follows an expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Memory-mapped word offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_COUNT = 8'h04;

    // Configuration space indices
    localparam logic [7:0] CFG_IDX_ENABLE = 8'h00;
    localparam logic [7:0] CFG_IDX_RES    = 8'h03;

    // Control word bit positions
    localparam int BIT_START  = 0;
    localparam int BIT_FIRED  = 1;
    localparam int BIT_ACTION = 2;
    localparam int BIT_TRIG   = 7;
    // Enable bit inside configuration index 0
    localparam int BIT_EN     = 7;

    typedef enum logic [1:0] {
        RES_FINE  = 2'b00,
        RES_SHORT = 2'b01,
        RES_MED   = 2'b10,
        RES_LONG  = 2'b11
    } res_e;

    typedef enum logic {
        ACT_REBOOT   = 1'b0,
        ACT_SHUTDOWN = 1'b1
    } action_e;

    typedef struct packed {
        logic    start;
        action_e action;
        logic    fired;
    } ctrl_t;

    typedef struct packed {
        logic    start;
        logic    trig;
        logic    clr_fired;
        action_e action;
    } ctrl_wr_t;

    function automatic logic [31:0] pack_ctrl(ctrl_t c);
        logic [31:0] w;
        w             = '0;
        w[BIT_START]  = c.start;
        w[BIT_FIRED]  = c.fired;
        w[BIT_ACTION] = c.action;
        return w;
    endfunction

    function automatic ctrl_wr_t decode_ctrl(logic [31:0] w);
        ctrl_wr_t d;
        d.start     = w[BIT_START];
        d.trig      = w[BIT_TRIG];
        d.clr_fired = w[BIT_FIRED];
        d.action    = action_e'(w[BIT_ACTION]);
        return d;
    endfunction

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       sel_data,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       en,
    output res_e       res
);
    logic [7:0] idx_q;
    logic       en_q;
    res_e       res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            en_q  <= 1'b0;
            res_q <= RES_FINE;
        end else if (wr) begin
            if (!sel_data) begin
                idx_q <= wdata;
            end else begin
                case (idx_q)
                    CFG_IDX_ENABLE: en_q  <= wdata[BIT_EN];
                    CFG_IDX_RES:    res_q <= res_e'(wdata[1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!sel_data) begin
            rdata = idx_q;
        end else begin
            case (idx_q)
                CFG_IDX_ENABLE: rdata[BIT_EN] = en_q;
                CFG_IDX_RES:    rdata[1:0]    = res_q;
                default: ;
            endcase
        end
    end

    assign en  = en_q;
    assign res = res_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(en_q) && $stable(res_q))) else $error("cfg changed without write"); // R1

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
    import wdog_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 100,
    parameter int unsigned RES0_US    = 32,
    parameter int unsigned RES1_US    = 10000,
    parameter int unsigned RES2_US    = 100000,
    parameter int unsigned RES3_US    = 1000000,
    parameter int unsigned PRE_W      = 27
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  res_e res,
    output logic tick
);
    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] len;
    res_e             res_q;
    logic             res_chg;
    logic             clr;

    always_comb begin
        case (res)
            RES_FINE:  len = PRE_W'(RES0_US * CYC_PER_US);
            RES_SHORT: len = PRE_W'(RES1_US * CYC_PER_US);
            RES_MED:   len = PRE_W'(RES2_US * CYC_PER_US);
            default:   len = PRE_W'(RES3_US * CYC_PER_US);
        endcase
    end

    assign res_chg = (res != res_q);
    assign clr     = restart || !run || res_chg;
    assign tick    = run && !clr && (pcnt_q == len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
            res_q  <= RES_FINE;
        end else begin
            res_q <= res;
            if (clr || tick) pcnt_q <= '0;
            else             pcnt_q <= pcnt_q + 1'b1;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        !res_chg |-> (pcnt_q < len)) else $error("prescaler past period"); // R6
    AST_RESCHG_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        res_chg |=> !tick) else $error("tick right after resolution change"); // R7

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        en,
    input  logic        wr,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        tick,
    output logic        run,
    output logic        restart,
    output logic        reboot_req,
    output logic        shutdown_req
);
    localparam int unsigned PAD_W = 32 - CNT_W;

    logic             soft_rst;
    logic             start_q;
    action_e          action_q;
    logic             fired_q;
    logic             halt_q;
    logic [CNT_W-1:0] tmo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             reboot_q;
    logic             shutdown_q;

    ctrl_wr_t cw;
    ctrl_t    cr;
    logic     sel_ctrl;
    logic     sel_cnt;
    logic     reload;
    logic     start_rise;
    logic     expire;

    assign soft_rst   = rst || por;
    assign cw         = decode_ctrl(wdata);
    assign sel_ctrl   = en && wr && (addr == OFS_CTRL);
    assign sel_cnt    = en && wr && (addr == OFS_COUNT);
    assign reload     = sel_ctrl && cw.trig;
    assign start_rise = sel_ctrl && cw.start && !start_q;
    assign run        = en && start_q && !halt_q;
    assign restart    = reload;
    assign expire     = tick && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (soft_rst) begin
            start_q    <= 1'b0;
            action_q   <= ACT_REBOOT;
            halt_q     <= 1'b0;
            tmo_q      <= '0;
            cnt_q      <= '0;
            reboot_q   <= 1'b0;
            shutdown_q <= 1'b0;
        end else begin
            if (sel_ctrl) begin
                start_q  <= cw.start;
                action_q <= cw.action;
            end
            if (sel_cnt) tmo_q <= wdata[CNT_W-1:0];
            if (reload)                      cnt_q <= tmo_q;
            else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
            if (reload || start_rise) halt_q <= 1'b0;
            else if (expire)          halt_q <= 1'b1;
            reboot_q   <= expire && (action_q == ACT_REBOOT);
            shutdown_q <= expire && (action_q == ACT_SHUTDOWN);
        end
    end

    // Fired status: only power-on reset clears it, expiry wins over a clear
    always_ff @(posedge clk) begin
        if (por)                          fired_q <= 1'b0;
        else if (expire)                  fired_q <= 1'b1;
        else if (sel_ctrl && cw.clr_fired) fired_q <= 1'b0;
    end

    always_comb begin
        cr.start  = start_q;
        cr.action = action_q;
        cr.fired  = fired_q;
        rdata     = '0;
        if (en) begin
            if (addr == OFS_CTRL)       rdata = pack_ctrl(cr);
            else if (addr == OFS_COUNT) rdata = {{PAD_W{1'b0}}, cnt_q};
        end
    end

    assign reboot_req   = reboot_q;
    assign shutdown_req = shutdown_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (soft_rst)
        $onehot0({reboot_q, shutdown_q})) else $error("both requests high"); // R9
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (soft_rst)
        (reboot_q || shutdown_q) |=> !(reboot_q || shutdown_q)) else $error("request longer than one cycle"); // R9
    AST_FIRED_SET: assert property (@(posedge clk) disable iff (soft_rst)
        (reboot_q || shutdown_q) |-> fired_q) else $error("request without fired"); // R10
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (soft_rst)
        (!run && !reload) |=> $stable(cnt_q)) else $error("count moved while stopped"); // R8
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (soft_rst)
        (tick && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("bad decrement"); // R5
    AST_DISABLED_NOWRITE: assert property (@(posedge clk) disable iff (soft_rst)
        !en |=> ($stable(start_q) && $stable(tmo_q))) else $error("write while disabled"); // R2

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 100,
    parameter int unsigned RES0_US    = 32,
    parameter int unsigned RES1_US    = 10000,
    parameter int unsigned RES2_US    = 100000,
    parameter int unsigned RES3_US    = 1000000,
    parameter int unsigned CNT_W      = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cfg_wr,
    input  logic        cfg_sel_data,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    output logic        reboot_req,
    output logic        shutdown_req
);
    localparam int unsigned MAX_US  = max4(RES0_US, RES1_US, RES2_US, RES3_US);
    localparam int unsigned MAX_LEN = MAX_US * CYC_PER_US;
    localparam int unsigned PRE_W   = $clog2(MAX_LEN + 1);

    logic rst_any;
    logic en;
    res_e res;
    logic tick;
    logic run;
    logic restart;

    assign rst_any = rst || por;

    wdog_cfg u_cfg (
        .clk      (clk),
        .rst      (rst_any),
        .wr       (cfg_wr),
        .sel_data (cfg_sel_data),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .en       (en),
        .res      (res)
    );

    wdog_prescale #(
        .CYC_PER_US (CYC_PER_US),
        .RES0_US    (RES0_US),
        .RES1_US    (RES1_US),
        .RES2_US    (RES2_US),
        .RES3_US    (RES3_US),
        .PRE_W      (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst     (rst_any),
        .run     (run),
        .restart (restart),
        .res     (res),
        .tick    (tick)
    );

    wdog_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk          (clk),
        .rst          (rst),
        .por          (por),
        .en           (en),
        .wr           (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .tick         (tick),
        .run          (run),
        .restart      (restart),
        .reboot_req   (reboot_req),
        .shutdown_req (shutdown_req)
    );

endmodule

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
    localparam int CPU = 2;
    localparam int R0 = 3, R1U = 5, R2U = 7, R3U = 11;

    logic        clk = 1'b0;
    logic        rst, por;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        cfg_wr, cfg_sel_data;
    logic [7:0]  cfg_wdata, cfg_rdata;
    logic        reboot_req, shutdown_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_top #(
        .CYC_PER_US (CPU), .RES0_US (R0), .RES1_US (R1U),
        .RES2_US (R2U), .RES3_US (R3U), .CNT_W (16)
    ) u0 (
        .clk (clk), .rst (rst), .por (por),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .cfg_wr (cfg_wr), .cfg_sel_data (cfg_sel_data), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .reboot_req (reboot_req), .shutdown_req (shutdown_req)
    );

    function automatic int tlen(int code);
        case (code)
            0: return R0 * CPU;
            1: return R1U * CPU;
            2: return R2U * CPU;
            default: return R3U * CPU;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic cfg_write(logic sel, logic [7:0] d);
        cfg_wr = 1'b1; cfg_sel_data = sel; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_set(logic [7:0] idx, logic [7:0] d);
        cfg_write(1'b0, idx);
        cfg_write(1'b1, d);
    endtask

    task automatic cfg_get(logic [7:0] idx, output logic [7:0] d);
        cfg_write(1'b0, idx);
        cfg_sel_data = 1'b1; #1; d = cfg_rdata;
    endtask

    task automatic reqs(string tag, logic rb, logic sd);
        chk(tag, {30'b0, reboot_req, shutdown_req}, {30'b0, rb, sd});
    endtask

    initial begin
        logic [31:0] rd;
        logic [7:0]  cb;
        int          len, tmo;
        rst = 1'b1; por = 1'b1;
        reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        cfg_wr = 0; cfg_sel_data = 0; cfg_wdata = 0;
        cyc(3);
        rst = 1'b0; por = 1'b0;

        // Reset state
        cfg_get(8'h00, cb);  chk("R1 reset enable", {24'b0, cb}, 32'h0);
        cfg_get(8'h03, cb);  chk("R1 reset res", {24'b0, cb}, 32'h0);
        reg_read(8'h00, rd); chk("R2 reset ctrl", rd, 32'h0);
        reqs("R9 reset requests", 1'b0, 1'b0);

        // Disabled decode
        reg_write(8'h04, 32'h5);
        reg_write(8'h00, 32'h81);
        cyc(20);
        reqs("R2 no run while disabled", 1'b0, 1'b0);
        cfg_set(8'h00, 8'hFF);
        reg_read(8'h00, rd); chk("R2 ctrl write ignored", rd, 32'h0);
        reg_read(8'h04, rd); chk("R2 count write ignored", rd, 32'h0);

        // Configuration space readback
        cfg_get(8'h00, cb);  chk("R1 enable bit only", {24'b0, cb}, 32'h80);
        cfg_set(8'h03, 8'hFE);
        cfg_get(8'h03, cb);  chk("R1 res field only", {24'b0, cb}, 32'h2);
        cfg_set(8'h05, 8'hFF);
        cfg_get(8'h05, cb);  chk("R1 other index zero", {24'b0, cb}, 32'h0);
        cfg_write(1'b0, 8'h03);
        cfg_sel_data = 1'b0; #1; chk("R1 index readback", {24'b0, cfg_rdata}, 32'h3);

        // Sweep all tick selects through a full countdown
        for (int code = 0; code < 4; code++) begin
            logic act;
            act = code[0];
            len = tlen(code);
            tmo = 3;
            cfg_set(8'h03, 8'(code));
            reg_write(8'h04, 32'(tmo));
            reg_write(8'h00, {24'b0, 1'b1, 4'b0, act, 1'b0, 1'b1});
            reg_read(8'h04, rd); chk("R5 loaded on trigger", rd, 32'(tmo));
            for (int k = 1; k <= tmo; k++) begin
                cyc(len - 1);
                reg_read(8'h04, rd); chk("R6 before tick", rd, 32'(tmo - k + 1));
                reqs("R9 no early request", 1'b0, 1'b0);
                cyc(1);
                reg_read(8'h04, rd); chk("R6 after tick", rd, 32'(tmo - k));
            end
            reqs("R9 expiry request", !act, act);
            reg_read(8'h00, rd); chk("R10 fired at expiry", rd, {29'b0, act, 2'b11});
            cyc(1);
            reqs("R9 single cycle", 1'b0, 1'b0);
            cyc(2 * len);
            reg_read(8'h04, rd); chk("R9 halted count", rd, 32'h0);
            reqs("R9 halted no request", 1'b0, 1'b0);
            reg_write(8'h00, {29'b0, act, 2'b01});
            reg_read(8'h00, rd); chk("R10 write 0 keeps fired", rd, {29'b0, act, 2'b11});
            reg_write(8'h00, 32'h2);
            reg_read(8'h00, rd); chk("R10 write 1 clears fired", rd, 32'h0);
        end

        // Mid-count trigger, then stop
        cfg_set(8'h03, 8'h0);
        len = tlen(0);
        reg_write(8'h04, 32'h5);
        reg_write(8'h00, 32'h81);
        cyc(2 * len + 3);
        reg_read(8'h04, rd); chk("R5 count before retrigger", rd, 32'h3);
        reg_write(8'h00, 32'h81);
        reg_read(8'h04, rd); chk("R5 retrigger reload", rd, 32'h5);
        cyc(len - 1);
        reg_read(8'h04, rd); chk("R5 full period after retrigger", rd, 32'h5);
        cyc(1);
        reg_read(8'h04, rd); chk("R5 decrement after retrigger", rd, 32'h4);
        reg_write(8'h00, 32'h0);
        cyc(40);
        reg_read(8'h04, rd); chk("R8 stopped count frozen", rd, 32'h4);
        reqs("R8 no request while stopped", 1'b0, 1'b0);

        // Resolution change mid-tick
        reg_write(8'h04, 32'h4);
        reg_write(8'h00, 32'h81);
        cyc(len + 2);
        reg_read(8'h04, rd); chk("R7 count before change", rd, 32'h3);
        cfg_set(8'h03, 8'h1);
        cyc(tlen(1));
        reg_read(8'h04, rd); chk("R7 no tick at old phase", rd, 32'h3);
        cyc(1);
        reg_read(8'h04, rd); chk("R7 tick one new period later", rd, 32'h2);
        reg_write(8'h00, 32'h0);
        cfg_set(8'h03, 8'h0);

        // Count width and reserved bits
        reg_write(8'h04, 32'hABCD0007);
        reg_write(8'h00, 32'h81);
        reg_read(8'h04, rd); chk("R4 upper bits dropped", rd, 32'h7);
        reg_write(8'h04, 32'h0000FFFF);
        reg_write(8'h00, 32'h81);
        reg_read(8'h04, rd); chk("R4 max timeout", rd, 32'hFFFF);
        cyc(len);
        reg_read(8'h04, rd); chk("R4 remaining after one tick", rd, 32'hFFFE);
        reg_write(8'h00, 32'h75);
        reg_read(8'h00, rd); chk("R3 reserved bits read zero", rd, 32'h5);
        reg_write(8'h00, 32'h85);
        reg_read(8'h00, rd); chk("R3 trigger reads zero", rd, 32'h5);
        reg_write(8'h00, 32'h0);

        // Fired survives warm reset, cleared by power-on reset
        reg_write(8'h04, 32'h1);
        reg_write(8'h00, 32'h81);
        cyc(len);
        reqs("R9 timeout of one", 1'b1, 1'b0);
        rst = 1'b1; cyc(2); rst = 1'b0;
        reg_read(8'h00, rd); chk("R11 decode off after warm reset", rd, 32'h0);
        cfg_set(8'h00, 8'h80);
        reg_read(8'h00, rd); chk("R11 fired survives warm reset", rd, 32'h2);
        reg_read(8'h04, rd); chk("R11 count cleared by warm reset", rd, 32'h0);
        por = 1'b1; cyc(2); por = 1'b0;
        cfg_set(8'h00, 8'h80);
        reg_read(8'h00, rd); chk("R11 fired cleared by por", rd, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule